// File: doc/BRIEF.md
# Doorbell and message interrupt unit

This block is a register bank with two access ports that carries interrupt requests between a local processor and an external PCI agent. The processor side writes two outbound message words and rings outbound doorbells. Each of these raises an interrupt request toward the PCI agent. The PCI side rings inbound doorbells, which raise an interrupt request toward the processor. Every request stays latched until the opposite side writes a 1 to its bit. The side that owns a mask register can mask the request, but the mask only gates the interrupt output. An event is always latched, and a pending bit drives its interrupt as soon as its mask is removed.

The two ports are identical in form. Each has a word address, write data, a write strobe, byte enables and a registered read data bus. Both ports can reach the same latched bits in the same cycle. The map below is shared by both ports (word addresses): 0 outbound message 0, 1 outbound message 1, 2 outbound status, 3 outbound mask, 4 outbound doorbell, 5 inbound doorbell, 6 inbound mask. All other addresses are unmapped.

Top module: `msg_doorbell_unit`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, and holds both interrupt outputs low.
- R2: A processor-side write to address 0 or 1 stores the enabled bytes of write data into that message word. Bytes that are not enabled keep their value, and PCI-side writes to these addresses have no effect.
- R3: A processor-side write to message word n with at least one byte enable set latches bit n of the outbound status word (address 2, bit 0 for word 0, bit 1 for word 1). Bits 31:2 of the status word read as zero.
- R4: A PCI-side write to the status word clears each status bit written as 1 in an enabled byte. Bits written as 0 are unchanged, and processor-side writes to the status word have no effect.
- R5: In the outbound doorbell (address 4), a processor-side write sets every bit written as 1 in an enabled byte. A PCI-side write clears every bit written as 1 in an enabled byte. Zeros and disabled bytes leave bits unchanged.
- R6: In the inbound doorbell (address 5), a PCI-side write sets every bit written as 1 in an enabled byte. A processor-side write clears every bit written as 1 in an enabled byte.
- R7: When a set and a clear reach the same doorbell or status bit in the same cycle, the bit ends up set.
- R8: One cycle after the state changes, irq_to_pci equals the OR of two terms. The first is status bit 0 with mask bit 0 clear, or status bit 1 with mask bit 1 clear. The second is any outbound doorbell bit set while outbound mask bit 2 is clear.
- R9: One cycle after the state changes, irq_to_cpu is high exactly when some inbound doorbell bit is set whose inbound mask bit (same position) is 0.
- R10: The outbound mask (address 3, bits 2:0, upper bits read zero) is written only from the PCI side, using byte 0. The inbound mask (address 6, 32 bits) is written only from the processor side. A mask bit of 1 masks its source but never stops the bit from latching.
- R11: Either port reads any address, and the value appears on its read data the cycle after the address is presented. Unmapped addresses read zero, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor-side word address |
| cpu_wdata | input | DATA_W | Processor-side write data |
| cpu_we | input | 1 | Processor-side write strobe |
| cpu_be | input | DATA_W/8 | Processor-side byte enables |
| cpu_rdata | output | DATA_W | Processor-side read data, registered |
| pci_addr | input | ADDR_W | PCI-side word address |
| pci_wdata | input | DATA_W | PCI-side write data |
| pci_we | input | 1 | PCI-side write strobe |
| pci_be | input | DATA_W/8 | PCI-side byte enables |
| pci_rdata | output | DATA_W | PCI-side read data, registered |
| irq_to_pci | output | 1 | Interrupt request toward the PCI agent |
| irq_to_cpu | output | 1 | Interrupt request toward the processor |

## Verification
The bench builds the block with its defaults: a 32-bit data path, four byte lanes and a 4-bit address. This covers partial byte-enable writes on every lane and the nine unmapped addresses from 7 to 15. Random cycles often write from both ports to the same register with sparse data. That makes same-cycle set and clear collisions on doorbell and status bits common, along with masks that change while requests are already pending.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  // Word addresses of the shared register map.
  localparam int MDU_A_MSG0  = 0;
  localparam int MDU_A_STAT  = 2;
  localparam int MDU_A_OMASK = 3;
  localparam int MDU_A_ODB   = 4;
  localparam int MDU_A_IDB   = 5;
  localparam int MDU_A_IMASK = 6;
  localparam int MDU_N_REGS  = 7;

  // Outbound message words and the outbound mask layout.
  localparam int MDU_N_MSG         = 2;
  localparam int MDU_OMASK_W       = MDU_N_MSG + 1;
  localparam int MDU_OMASK_ODB_BIT = MDU_N_MSG;

endpackage

// File: rtl/mdu_side_decode.sv
module mdu_side_decode
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BE_W-1:0]       be,
  output logic [MDU_N_REGS-1:0] wr_sel,
  output logic [DATA_W-1:0]     bmask
);

  always_comb begin
    for (int r = 0; r < MDU_N_REGS; r++) begin
      wr_sel[r] = we && (addr == ADDR_W'(r));
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      bmask[i] = be[i/8];
    end
  end

endmodule

// File: rtl/mdu_byte_reg.sv
module mdu_byte_reg #(
  parameter int W     = 32,
  localparam int BE_W = (W + 7) / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [BE_W-1:0] be,
  input  logic [W-1:0]    d,
  output logic [W-1:0]    q
);

  logic [W-1:0] lane_mask;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      lane_mask[i] = we && be[i/8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~lane_mask) | (d & lane_mask);
  end

endmodule

// File: rtl/mdu_setclr_reg.sv
module mdu_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);

  // Clear first, then set: a colliding set survives.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_bits) | set_bits;
  end

endmodule

// File: rtl/mdu_read_port.sv
module mdu_read_port
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [MDU_N_REGS-1:0][DATA_W-1:0] bank,
  output logic [DATA_W-1:0]                 rdata
);

  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int r = 0; r < MDU_N_REGS; r++) begin
      if (addr == ADDR_W'(r)) pick = bank[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= pick;
  end

endmodule

// File: rtl/mdu_irq_gen.sv
module mdu_irq_gen
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MDU_N_MSG-1:0]   stat,
  input  logic [MDU_OMASK_W-1:0] omask,
  input  logic [DATA_W-1:0]      odb,
  input  logic [DATA_W-1:0]      idb,
  input  logic [DATA_W-1:0]      imask,
  output logic                   irq_to_pci,
  output logic                   irq_to_cpu
);

  logic msg_live, odb_live, idb_live;

  always_comb begin
    msg_live = |(stat & ~omask[MDU_N_MSG-1:0]);
    odb_live = (|odb) && !omask[MDU_OMASK_ODB_BIT];
    idb_live = |(idb & ~imask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_to_pci <= 1'b0;
      irq_to_cpu <= 1'b0;
    end else begin
      irq_to_pci <= msg_live || odb_live;
      irq_to_cpu <= idb_live;
    end
  end

endmodule

// File: rtl/msg_doorbell_unit.sv
module msg_doorbell_unit
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [BE_W-1:0]   cpu_be,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic [DATA_W-1:0] pci_wdata,
  input  logic              pci_we,
  input  logic [BE_W-1:0]   pci_be,
  output logic [DATA_W-1:0] pci_rdata,
  output logic              irq_to_pci,
  output logic              irq_to_cpu
);

  logic [MDU_N_REGS-1:0] cpu_wr, pci_wr;
  logic [DATA_W-1:0]     cpu_bm, pci_bm;

  mdu_side_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cpu_dec (
    .we(cpu_we), .addr(cpu_addr), .be(cpu_be), .wr_sel(cpu_wr), .bmask(cpu_bm)
  );

  mdu_side_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pci_dec (
    .we(pci_we), .addr(pci_addr), .be(pci_be), .wr_sel(pci_wr), .bmask(pci_bm)
  );

  // Outbound message words, processor side only.
  logic [MDU_N_MSG-1:0][DATA_W-1:0] msg_q;
  logic [MDU_N_MSG-1:0]             stat_set;

  for (genvar m = 0; m < MDU_N_MSG; m++) begin : g_msg
    mdu_byte_reg #(.W(DATA_W)) u_msg (
      .clk(clk), .rst(rst), .we(cpu_wr[MDU_A_MSG0+m]),
      .be(cpu_be), .d(cpu_wdata), .q(msg_q[m])
    );
    assign stat_set[m] = cpu_wr[MDU_A_MSG0+m] && (|cpu_be);
  end

  // Outbound status: set by message writes, cleared by the PCI side.
  logic [MDU_N_MSG-1:0] stat_clr, stat_q;

  assign stat_clr = pci_wr[MDU_A_STAT]
                  ? (pci_wdata[MDU_N_MSG-1:0] & pci_bm[MDU_N_MSG-1:0]) : '0;

  mdu_setclr_reg #(.W(MDU_N_MSG)) u_stat (
    .clk(clk), .rst(rst), .set_bits(stat_set), .clr_bits(stat_clr), .q(stat_q)
  );

  // Outbound doorbell: processor sets, PCI clears.
  logic [DATA_W-1:0] odb_set, odb_clr, odb_q;

  assign odb_set = cpu_wr[MDU_A_ODB] ? (cpu_wdata & cpu_bm) : '0;
  assign odb_clr = pci_wr[MDU_A_ODB] ? (pci_wdata & pci_bm) : '0;

  mdu_setclr_reg #(.W(DATA_W)) u_odb (
    .clk(clk), .rst(rst), .set_bits(odb_set), .clr_bits(odb_clr), .q(odb_q)
  );

  // Inbound doorbell: PCI sets, processor clears.
  logic [DATA_W-1:0] idb_set, idb_clr, idb_q;

  assign idb_set = pci_wr[MDU_A_IDB] ? (pci_wdata & pci_bm) : '0;
  assign idb_clr = cpu_wr[MDU_A_IDB] ? (cpu_wdata & cpu_bm) : '0;

  mdu_setclr_reg #(.W(DATA_W)) u_idb (
    .clk(clk), .rst(rst), .set_bits(idb_set), .clr_bits(idb_clr), .q(idb_q)
  );

  // Masks: outbound owned by the PCI side, inbound by the processor side.
  logic [MDU_OMASK_W-1:0] omask_q;
  logic [DATA_W-1:0]      imask_q;

  mdu_byte_reg #(.W(MDU_OMASK_W)) u_omask (
    .clk(clk), .rst(rst), .we(pci_wr[MDU_A_OMASK]),
    .be(pci_be[0]), .d(pci_wdata[MDU_OMASK_W-1:0]), .q(omask_q)
  );

  mdu_byte_reg #(.W(DATA_W)) u_imask (
    .clk(clk), .rst(rst), .we(cpu_wr[MDU_A_IMASK]),
    .be(cpu_be), .d(cpu_wdata), .q(imask_q)
  );

  // Read bank shared by both ports.
  logic [MDU_N_REGS-1:0][DATA_W-1:0] bank;

  always_comb begin
    for (int m = 0; m < MDU_N_MSG; m++) bank[MDU_A_MSG0+m] = msg_q[m];
    bank[MDU_A_STAT]  = DATA_W'(stat_q);
    bank[MDU_A_OMASK] = DATA_W'(omask_q);
    bank[MDU_A_ODB]   = odb_q;
    bank[MDU_A_IDB]   = idb_q;
    bank[MDU_A_IMASK] = imask_q;
  end

  mdu_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cpu_rd (
    .clk(clk), .rst(rst), .addr(cpu_addr), .bank(bank), .rdata(cpu_rdata)
  );

  mdu_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pci_rd (
    .clk(clk), .rst(rst), .addr(pci_addr), .bank(bank), .rdata(pci_rdata)
  );

  mdu_irq_gen #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .stat(stat_q), .omask(omask_q),
    .odb(odb_q), .idb(idb_q), .imask(imask_q),
    .irq_to_pci(irq_to_pci), .irq_to_cpu(irq_to_cpu)
  );

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic [DATA_W-1:0]    cpu_wdata,
  input logic                 cpu_we,
  input logic [BE_W-1:0]      cpu_be,
  input logic [ADDR_W-1:0]    pci_addr,
  input logic [DATA_W-1:0]    pci_wdata,
  input logic                 pci_we,
  input logic [BE_W-1:0]      pci_be,
  input logic                 irq_to_pci,
  input logic                 irq_to_cpu,
  input logic [MDU_N_MSG-1:0] stat_q,
  input logic [DATA_W-1:0]    msg0_q,
  input logic [DATA_W-1:0]    odb_q,
  input logic [DATA_W-1:0]    idb_q
);

  logic cpu_hits_msg0, cpu_hits_msg, pci_hits_stat;
  logic cpu_odb_b0, pci_odb_b0, cpu_idb_b0, pci_idb_b0;

  always_comb begin
    cpu_hits_msg0 = cpu_we && (cpu_addr == ADDR_W'(MDU_A_MSG0));
    cpu_hits_msg  = cpu_we && (cpu_addr < ADDR_W'(MDU_A_MSG0 + MDU_N_MSG));
    pci_hits_stat = pci_we && (pci_addr == ADDR_W'(MDU_A_STAT));
    cpu_odb_b0 = cpu_we && (cpu_addr == ADDR_W'(MDU_A_ODB)) && cpu_be[0] && cpu_wdata[0];
    pci_odb_b0 = pci_we && (pci_addr == ADDR_W'(MDU_A_ODB)) && pci_be[0] && pci_wdata[0];
    cpu_idb_b0 = cpu_we && (cpu_addr == ADDR_W'(MDU_A_IDB)) && cpu_be[0] && cpu_wdata[0];
    pci_idb_b0 = pci_we && (pci_addr == ADDR_W'(MDU_A_IDB)) && pci_be[0] && pci_wdata[0];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_to_pci && !irq_to_cpu && stat_q == '0));

  assert_msg_only_cpu_R2: assert property (@(posedge clk) disable iff (rst)
    !cpu_hits_msg0 |=> $stable(msg0_q));

  assert_msg_sets_status_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_hits_msg0 && (|cpu_be)) |=> stat_q[0]);

  assert_status_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!cpu_hits_msg && !pci_hits_stat) |=> $stable(stat_q));

  assert_pci_clears_odb_R5: assert property (@(posedge clk) disable iff (rst)
    (pci_odb_b0 && !cpu_odb_b0) |=> !odb_q[0]);

  assert_cpu_clears_idb_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_idb_b0 && !pci_idb_b0) |=> !idb_q[0]);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_odb_b0 && pci_odb_b0) |=> odb_q[0]);

  assert_idle_pci_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (odb_q == '0 && stat_q == '0) |=> !irq_to_pci);

  assert_idle_cpu_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (idb_q == '0) |=> !irq_to_cpu);

endmodule

bind msg_doorbell_unit mdu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mdu_chk (
  .clk(clk), .rst(rst),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_be(cpu_be),
  .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_we(pci_we), .pci_be(pci_be),
  .irq_to_pci(irq_to_pci), .irq_to_cpu(irq_to_cpu),
  .stat_q(stat_q), .msg0_q(msg_q[0]), .odb_q(odb_q), .idb_q(idb_q)
);

// File: tb/test_msg_doorbell_unit.sv
`timescale 1ns/1ps
module test_msg_doorbell_unit;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0, pci_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, pci_wdata = '0;
  logic          cpu_we = 1'b0, pci_we = 1'b0;
  logic [BW-1:0] cpu_be = '0, pci_be = '0;
  logic [DW-1:0] cpu_rdata, pci_rdata;
  logic          irq_to_pci, irq_to_cpu;

  msg_doorbell_unit #(.DATA_W(DW), .ADDR_W(AW)) i_msg_doorbell_unit (
    .clk(clk), .rst(rst),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_rdata(cpu_rdata),
    .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_we(pci_we), .pci_be(pci_be),
    .pci_rdata(pci_rdata),
    .irq_to_pci(irq_to_pci), .irq_to_cpu(irq_to_cpu)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference state, updated from the requirements.
  logic [DW-1:0] m_msg0, m_msg1, m_odb, m_idb, m_imask;
  logic [1:0]    m_stat;
  logic [2:0]    m_omask;

  function automatic logic [DW-1:0] lanes(input logic [BW-1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = be[i/8];
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_read(input int a);
    case (a)
      0: return m_msg0;
      1: return m_msg1;
      2: return {30'd0, m_stat};
      3: return {29'd0, m_omask};
      4: return m_odb;
      5: return m_idb;
      6: return m_imask;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0, 1:    return "R2";
      2:       return "R4";
      3, 6:    return "R10";
      4:       return "R5";
      5:       return "R6";
      default: return "R11";
    endcase
  endfunction

  function automatic logic exp_irq_pci();
    return (|(m_stat & ~m_omask[1:0])) || ((|m_odb) && !m_omask[2]);
  endfunction

  function automatic logic exp_irq_cpu();
    return |(m_idb & ~m_imask);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_msg0 = '0; m_msg1 = '0; m_odb = '0; m_idb = '0; m_imask = '0;
    m_stat = '0; m_omask = '0;
  endtask

  task automatic model_step(
    input logic cwe, input int ca, input logic [DW-1:0] cd, input logic [BW-1:0] cbe,
    input logic pwe, input int pa, input logic [DW-1:0] pd, input logic [BW-1:0] pbe);
    logic [DW-1:0] cbm, pbm, s, c;
    logic [1:0] ss, sc;
    cbm = lanes(cbe);
    pbm = lanes(pbe);
    if (cwe && ca == 0) m_msg0 = (m_msg0 & ~cbm) | (cd & cbm);
    if (cwe && ca == 1) m_msg1 = (m_msg1 & ~cbm) | (cd & cbm);
    ss = '0;
    if (cwe && ca == 0 && cbe != 0) ss[0] = 1'b1;
    if (cwe && ca == 1 && cbe != 0) ss[1] = 1'b1;
    sc = (pwe && pa == 2) ? (pd[1:0] & pbm[1:0]) : 2'b00;
    m_stat = (m_stat & ~sc) | ss;
    if (pwe && pa == 3 && pbe[0]) m_omask = pd[2:0];
    s = (cwe && ca == 4) ? (cd & cbm) : '0;
    c = (pwe && pa == 4) ? (pd & pbm) : '0;
    m_odb = (m_odb & ~c) | s;
    s = (pwe && pa == 5) ? (pd & pbm) : '0;
    c = (cwe && ca == 5) ? (cd & cbm) : '0;
    m_idb = (m_idb & ~c) | s;
    if (cwe && ca == 6) m_imask = (m_imask & ~cbm) | (cd & cbm);
  endtask

  task automatic cyc(
    input logic cwe, input int ca, input logic [DW-1:0] cd, input logic [BW-1:0] cbe,
    input logic pwe, input int pa, input logic [DW-1:0] pd, input logic [BW-1:0] pbe);
    @(negedge clk);
    cpu_we = cwe; cpu_addr = AW'(ca); cpu_wdata = cd; cpu_be = cbe;
    pci_we = pwe; pci_addr = AW'(pa); pci_wdata = pd; pci_be = pbe;
    @(posedge clk);
    model_step(cwe, ca, cd, cbe, pwe, pa, pd, pbe);
    @(negedge clk);
    cpu_we = 1'b0; pci_we = 1'b0;
  endtask

  // Reads every mapped word and one unmapped word from both ports, then the interrupts.
  task automatic sweep();
    int un;
    un = 7 + int'($urandom % 9);
    for (int k = 0; k < 8; k++) begin
      int a;
      a = (k == 7) ? un : k;
      @(negedge clk);
      cpu_addr = AW'(a);
      pci_addr = AW'((k == 7) ? a : 6 - k);
      @(posedge clk);
      #2;
      chk(req_of(a), cpu_rdata, exp_read(a));
      chk(req_of((k == 7) ? a : 6 - k), pci_rdata, exp_read((k == 7) ? a : 6 - k));
    end
    chk("R8", {31'd0, irq_to_pci}, {31'd0, exp_irq_pci()});
    chk("R9", {31'd0, irq_to_cpu}, {31'd0, exp_irq_cpu()});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b11));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: everything zero out of reset.
    #1;
    chk("R1", {30'd0, irq_to_pci, irq_to_cpu}, '0);
    sweep();

    // R3: partial-byte write to message 1 latches status bit 1 only.
    cyc(1'b1, 1, 32'hA5A5_A5A5, 4'b0001, 1'b0, 0, '0, '0);
    sweep();
    chk("R3", {30'd0, m_stat}, 32'h2);

    // R4: PCI writes 0 to status, then 1.
    cyc(1'b0, 0, '0, '0, 1'b1, 2, 32'h0, 4'hF);
    sweep();
    cyc(1'b0, 0, '0, '0, 1'b1, 2, 32'h2, 4'hF);
    sweep();

    // R10: masked inbound doorbell still latches; unmasking raises the request.
    cyc(1'b1, 6, 32'hFFFF_FFFF, 4'hF, 1'b1, 5, 32'h0000_0100, 4'hF);
    sweep();
    chk("R10", {31'd0, irq_to_cpu}, 32'd0);
    cyc(1'b1, 6, 32'h0, 4'h2, 1'b0, 0, '0, '0);
    sweep();
    chk("R10", {31'd0, irq_to_cpu}, 32'd1);

    // R7: same-cycle set and clear on both doorbells.
    cyc(1'b1, 4, 32'h0000_0010, 4'hF, 1'b0, 0, '0, '0);
    cyc(1'b1, 4, 32'h0000_00F0, 4'hF, 1'b1, 4, 32'h0000_00F0, 4'hF);
    sweep();
    chk("R7", m_odb, 32'h0000_00F0);
    cyc(1'b1, 5, 32'h0000_0100, 4'hF, 1'b1, 5, 32'h0000_0100, 4'hF);
    sweep();
    chk("R7", m_idb, 32'h0000_0100);

    // R8: masking the doorbell source in the outbound mask.
    cyc(1'b0, 0, '0, '0, 1'b1, 3, 32'h0000_0007, 4'h1);
    sweep();
    cyc(1'b0, 0, '0, '0, 1'b1, 3, 32'h0000_0003, 4'h1);
    sweep();

    // Random mix of both ports.
    for (int it = 0; it < 300; it++) begin
      logic cwe, pwe;
      int ca, pa;
      logic [DW-1:0] cd, pd;
      logic [BW-1:0] cbe, pbe;
      cwe = ($urandom % 4) != 0;
      pwe = ($urandom % 4) != 0;
      ca  = ($urandom % 5 == 0) ? int'($urandom % 16) : int'($urandom % 7);
      pa  = ($urandom % 3 == 0) ? ca : int'($urandom % 7);
      cd  = $urandom & $urandom & $urandom;
      pd  = $urandom & $urandom;
      cbe = BW'($urandom);
      pbe = BW'($urandom);
      cyc(cwe, ca, cd, cbe, pwe, pa, pd, pbe);
      sweep();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule